// File: doc/BRIEF.md
# Split-I/O Static Memory

This block is a synthesizable functional stand-in for an asynchronous static memory with a separate input data bus and output data bus. Two active-low chip selects must both be low for the memory to respond. A low write strobe under that selection opens a write window. A high write strobe under that selection makes a read, and the addressed word is shown on the output bus. The word depth is 2^ADDR_W words of DATA_W bits. The device being modelled uses ADDR_W = 14 and DATA_W = 4, which gives 16K by 4. The default elaboration is a smaller 1K-word instance.

All pins are sampled on a fast internal clock, so the block contains no latches and no tri-states. A high-impedance output is shown as a drive-enable flag, with the data bus forced to zero while that flag is low. A write is committed when its window closes, which happens when the first of the three strobes returns high. The word and address committed are those sampled in the last clock cycle of the window.

The parameter `VARIANT` selects how the outputs behave during writes. `OUT_FLOAT` stops driving while a write strobe is low, and it honours an active-low output enable. `OUT_PASS` echoes the incoming word during a write and ignores the output enable. A sleep flag reports that the memory is deselected.

Top module: `sio_sram`

## Requirements
- R1: While reset is held, and on the first clock after its release, `rdata_drv` is 0, `rdata` is 0 and `sleep` is 1.
- R2: Consider pins that hold both selects low and `wr_n` high (plus `out_en_n` low in `OUT_FLOAT`). Two clock edges later, `rdata_drv` is 1 and `rdata` equals the stored word at `addr`.
- R3: A write window is open while `cs_a_n`, `cs_b_n` and `wr_n` are all low. When the window closes because `wr_n` rises, the `wdata` and `addr` sampled in the last cycle of the window are stored.
- R4: A window that closes because only `cs_a_n` rises commits the write. The same holds when only `cs_b_n` rises.
- R5: A change of `wdata` in the same cycle that closes the window is not stored. The stored word is the one held during the window.
- R6: While either select is high, `rdata_drv` is 0, `rdata` is 0, and a low `wr_n` writes nothing.
- R7: In `OUT_FLOAT`, `rdata_drv` is 0 and `rdata` is 0 whenever the sampled `wr_n` is low or `out_en_n` is high.
- R8: In `OUT_PASS`, during an open window `rdata_drv` is 1 and `rdata` equals `wdata` as sampled two edges earlier. `out_en_n` has no effect in this variant.
- R9: If a window closes while both selects stay low and the address is unchanged, the very first read output already shows the newly written word.
- R10: `sleep` equals, two edges later, the OR of `cs_a_n` and `cs_b_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_a_n | input | 1 | First chip select, active low |
| cs_b_n | input | 1 | Second chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| out_en_n | input | 1 | Output enable, active low (used by OUT_FLOAT only) |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Input data bus |
| rdata | output | DATA_W | Output data bus, zero when not driven |
| rdata_drv | output | 1 | Output drive enable (0 = high impedance) |
| sleep | output | 1 | Deselected flag |

## Verification
Two functions can fall in the same cycle: the commit of a write whose window has just closed, and a read of that same word. The bench provokes this by raising only `wr_n` while both selects stay low and the address stays fixed. It judges the result on the first cycle the read reaches the output bus. That cycle must already carry the new word and not the word stored before. The word stored before is deliberately chosen to differ from the new one, so that a stale read is visible.

// File: rtl/sio_sram_pkg.sv
package sio_sram_pkg;

   // Output behaviour while a write window is open
   typedef enum logic {
      OUT_FLOAT = 1'b0,
      OUT_PASS  = 1'b1
   } wr_out_e;

   localparam int unsigned MAX_ADDR_W = 14;

   function automatic logic both_low(input logic a_n, input logic b_n);
      return !a_n && !b_n;
   endfunction

endpackage

// File: rtl/sio_sram_sampler.sv
module sio_sram_sampler #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_a_n,
   input  logic              cs_b_n,
   input  logic              wr_n,
   input  logic              out_en_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              cs_a_n_s,
   output logic              cs_b_n_s,
   output logic              wr_n_s,
   output logic              out_en_n_s,
   output logic [ADDR_W-1:0] addr_s,
   output logic [DATA_W-1:0] wdata_s
);

   // Strobes reset to the inactive (deselected) level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_a_n_s   <= 1'b1;
         cs_b_n_s   <= 1'b1;
         wr_n_s     <= 1'b1;
         out_en_n_s <= 1'b1;
      end else begin
         cs_a_n_s   <= cs_a_n;
         cs_b_n_s   <= cs_b_n;
         wr_n_s     <= wr_n;
         out_en_n_s <= out_en_n;
      end
   end

   // Buses carry no control meaning and need no reset
   always_ff @(posedge clk) begin
      addr_s  <= addr;
      wdata_s <= wdata;
   end

endmodule

// File: rtl/sio_sram_wr_ctrl.sv
module sio_sram_wr_ctrl #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_a_n_s,
   input  logic              cs_b_n_s,
   input  logic              wr_n_s,
   input  logic [ADDR_W-1:0] addr_s,
   input  logic [DATA_W-1:0] wdata_s,
   output logic              win,
   output logic              commit,
   output logic [ADDR_W-1:0] c_addr,
   output logic [DATA_W-1:0] c_data
);
   import sio_sram_pkg::*;

   logic              win_q;
   logic [ADDR_W-1:0] hold_addr;
   logic [DATA_W-1:0] hold_data;

   // Window = overlap of both selects and the write strobe
   assign win = both_low(cs_a_n_s, cs_b_n_s) && !wr_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q <= 1'b0;
      else        win_q <= win;
   end

   // Track the last in-window sample; the closing sample is never taken
   always_ff @(posedge clk) begin
      if (win) begin
         hold_addr <= addr_s;
         hold_data <= wdata_s;
      end
   end

   assign commit = win_q && !win;
   assign c_addr = hold_addr;
   assign c_data = hold_data;

endmodule

// File: rtl/sio_sram_array.sv
module sio_sram_array #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              commit,
   input  logic [ADDR_W-1:0] c_addr,
   input  logic [DATA_W-1:0] c_data,
   input  logic [ADDR_W-1:0] r_addr,
   output logic [DATA_W-1:0] r_word
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic              hit;

   always_ff @(posedge clk) begin
      if (commit) mem[c_addr] <= c_data;
   end

   // Forward a commit that lands in the same cycle as a read of its word
   assign hit    = commit && (c_addr == r_addr);
   assign r_word = hit ? c_data : mem[r_addr];

endmodule

// File: rtl/sio_sram_out_stage.sv
module sio_sram_out_stage #(
   parameter int unsigned             DATA_W  = 4,
   parameter sio_sram_pkg::wr_out_e   VARIANT = sio_sram_pkg::OUT_FLOAT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr_n_s,
   input  logic              out_en_n_s,
   input  logic [DATA_W-1:0] rd_word,
   input  logic [DATA_W-1:0] wr_word,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_drv,
   output logic              sleep
);
   import sio_sram_pkg::*;

   logic              drive;
   logic [DATA_W-1:0] word;

   generate
      if (VARIANT == OUT_FLOAT) begin : g_float
         assign drive = sel && wr_n_s && !out_en_n_s;
         assign word  = rd_word;
         logic [DATA_W-1:0] unused_wr_word;
         assign unused_wr_word = wr_word;
      end else begin : g_pass
         assign drive = sel;
         assign word  = wr_n_s ? rd_word : wr_word;
         logic unused_oe;
         assign unused_oe = out_en_n_s;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_drv <= 1'b0;
         rdata     <= '0;
         sleep     <= 1'b1;
      end else begin
         rdata_drv <= drive;
         rdata     <= drive ? word : '0;
         sleep     <= !sel;
      end
   end

endmodule

// File: rtl/sio_sram.sv
module sio_sram #(
   parameter int unsigned           ADDR_W  = 10,
   parameter int unsigned           DATA_W  = 4,
   parameter sio_sram_pkg::wr_out_e VARIANT = sio_sram_pkg::OUT_FLOAT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_a_n,
   input  logic              cs_b_n,
   input  logic              wr_n,
   input  logic              out_en_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_drv,
   output logic              sleep
);
   import sio_sram_pkg::*;

   generate
      if (ADDR_W < 1 || ADDR_W > MAX_ADDR_W) begin : g_bad_addr_w
         $error("sio_sram: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("sio_sram: DATA_W must be at least 1");
      end
   endgenerate

   logic              cs_a_n_s, cs_b_n_s, wr_n_s, out_en_n_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] wdata_s;
   logic              win, commit;
   logic [ADDR_W-1:0] c_addr;
   logic [DATA_W-1:0] c_data;
   logic [DATA_W-1:0] rd_word;
   logic              sel;
   logic              unused_win;

   sio_sram_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sampler (
      .clk(clk), .rst_n(rst_n),
      .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .wr_n(wr_n), .out_en_n(out_en_n),
      .addr(addr), .wdata(wdata),
      .cs_a_n_s(cs_a_n_s), .cs_b_n_s(cs_b_n_s), .wr_n_s(wr_n_s),
      .out_en_n_s(out_en_n_s), .addr_s(addr_s), .wdata_s(wdata_s)
   );

   sio_sram_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wr_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cs_a_n_s(cs_a_n_s), .cs_b_n_s(cs_b_n_s), .wr_n_s(wr_n_s),
      .addr_s(addr_s), .wdata_s(wdata_s),
      .win(win), .commit(commit), .c_addr(c_addr), .c_data(c_data)
   );

   sio_sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
      .clk(clk), .commit(commit), .c_addr(c_addr), .c_data(c_data),
      .r_addr(addr_s), .r_word(rd_word)
   );

   assign sel        = both_low(cs_a_n_s, cs_b_n_s);
   assign unused_win = win;

   sio_sram_out_stage #(.DATA_W(DATA_W), .VARIANT(VARIANT)) i_out (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr_n_s(wr_n_s),
      .out_en_n_s(out_en_n_s), .rd_word(rd_word), .wr_word(wdata_s),
      .rdata(rdata), .rdata_drv(rdata_drv), .sleep(sleep)
   );

endmodule

// File: rtl/sio_sram_chk.sv
module sio_sram_chk #(
   parameter int unsigned           DATA_W  = 4,
   parameter sio_sram_pkg::wr_out_e VARIANT = sio_sram_pkg::OUT_FLOAT
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_a_n,
   input logic              cs_b_n,
   input logic              wr_n,
   input logic              out_en_n,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              rdata_drv,
   input logic              sleep
);
   import sio_sram_pkg::*;

   localparam logic PASS_MODE = (VARIANT == OUT_PASS);

   // Edges since reset release, saturating; pin history is valid at 3
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= 2'd0;
      else if (age != 3)  age <= age + 2'd1;
   end

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!rdata_drv && sleep && rdata == '0));                  // R1

   AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_drv |-> (rdata == '0));                                           // R6

   AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && $past(cs_a_n || cs_b_n, 2)) |-> !rdata_drv);             // R6

   AST_SLEEP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> (sleep == $past(cs_a_n || cs_b_n, 2)));                // R10

   AST_FLOAT_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!PASS_MODE && age == 2'd3 && $past(!wr_n || out_en_n, 2)) |-> !rdata_drv); // R7

   AST_PASS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      (PASS_MODE && age == 2'd3 && $past(!cs_a_n && !cs_b_n && !wr_n, 2))
      |-> (rdata_drv && rdata == $past(wdata, 2)));                            // R8

   AST_DRIVE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_drv |-> !sleep);                                                   // R2

endmodule

bind sio_sram sio_sram_chk #(.DATA_W(DATA_W), .VARIANT(VARIANT)) i_sio_sram_chk (
   .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .wr_n(wr_n),
   .out_en_n(out_en_n), .wdata(wdata), .rdata(rdata), .rdata_drv(rdata_drv),
   .sleep(sleep)
);

// File: tb/test_sio_sram.sv
module test_sio_sram;
   import sio_sram_pkg::*;

   localparam int unsigned AW       = 10;
   localparam int unsigned DW       = 4;
   localparam time         T_CLK    = 10ns;
   localparam int          WD_LIMIT = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_a_n = 1'b1, cs_b_n = 1'b1, wr_n = 1'b1, out_en_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rd_f, rd_p;
   logic          drv_f, drv_p, slp_f, slp_p;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(T_CLK/2) clk = ~clk;

   sio_sram #(.ADDR_W(AW), .DATA_W(DW), .VARIANT(OUT_FLOAT)) i_sio_sram (
      .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .wr_n(wr_n),
      .out_en_n(out_en_n), .addr(addr), .wdata(wdata),
      .rdata(rd_f), .rdata_drv(drv_f), .sleep(slp_f)
   );

   sio_sram #(.ADDR_W(AW), .DATA_W(DW), .VARIANT(OUT_PASS)) i_sio_sram_pass (
      .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .wr_n(wr_n),
      .out_en_n(out_en_n), .addr(addr), .wdata(wdata),
      .rdata(rd_p), .rdata_drv(drv_p), .sleep(slp_p)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pins(input logic a, input logic b, input logic w, input logic o,
                       input logic [AW-1:0] ad, input logic [DW-1:0] d);
      cs_a_n = a; cs_b_n = b; wr_n = w; out_en_n = o; addr = ad; wdata = d;
   endtask

   task automatic idle();
      pins(1, 1, 1, 1, addr, wdata);
      step(2);
   endtask

   task automatic put(input logic [AW-1:0] ad, input logic [DW-1:0] d);
      pins(0, 0, 0, 1, ad, d);
      step(2);
      pins(1, 1, 1, 1, ad, d);
      step(3);
   endtask

   // Read on both instances and compare with the expected word
   task automatic get(input string req, input logic [AW-1:0] ad, input logic [DW-1:0] exp);
      pins(0, 0, 1, 0, ad, '0);
      step(2);
      chk({req, " float word"}, rd_f, exp);
      chk({req, " pass word"},  rd_p, exp);
      chk("R2 float drive",     drv_f, 1);
      chk("R10 sleep low when selected", slp_f, 0);
      idle();
   endtask

   task automatic t_reset();
      step(3);
      chk("R1 drive in reset", drv_f, 0);
      chk("R1 data in reset",  rd_f, 0);
      chk("R1 sleep in reset", slp_f, 1);
      chk("R1 pass drive in reset", drv_p, 0);
      rst_n = 1'b1;
      step(1);
      chk("R1 drive after release", drv_f, 0);
      chk("R1 sleep after release", slp_p, 1);
   endtask

   task automatic t_basic();
      put(10'h000, 4'hA);
      put(10'h3FF, 4'h5);
      put(10'h003, 4'hF);
      put(10'h155, 4'h0);
      get("R3 addr 0",     10'h000, 4'hA);
      get("R3 addr max",   10'h3FF, 4'h5);
      get("R3 addr 3",     10'h003, 4'hF);
      get("R2 addr 155",   10'h155, 4'h0);
   endtask

   task automatic t_cs_end();
      pins(0, 0, 0, 1, 10'd7, 4'h9);
      step(2);
      pins(1, 0, 0, 1, 10'd7, 4'h9);   // only cs_a_n rises
      step(2);
      idle();
      pins(0, 0, 0, 1, 10'd8, 4'h6);
      step(2);
      pins(0, 1, 0, 1, 10'd8, 4'h6);   // only cs_b_n rises
      step(2);
      idle();
      get("R4 closed by cs_a", 10'd7, 4'h9);
      get("R4 closed by cs_b", 10'd8, 4'h6);
   endtask

   task automatic t_latch();
      pins(0, 0, 0, 1, 10'd9, 4'h3);
      step(2);
      pins(0, 0, 1, 1, 10'd9, 4'hC);   // data changes on the closing edge
      step(2);
      idle();
      get("R5 closing data ignored", 10'd9, 4'h3);
   endtask

   task automatic t_desel();
      pins(1, 0, 0, 0, 10'd0, 4'h5);
      step(2);
      chk("R6 cs_a high float drive", drv_f, 0);
      chk("R6 cs_a high float data",  rd_f, 0);
      chk("R6 cs_a high pass drive",  drv_p, 0);
      chk("R10 sleep with cs_a high", slp_f, 1);
      pins(0, 1, 0, 0, 10'd0, 4'h6);
      step(2);
      chk("R6 cs_b high pass drive",  drv_p, 0);
      chk("R10 sleep with cs_b high", slp_p, 1);
      idle();
      get("R6 no write while deselected", 10'd0, 4'hA);
   endtask

   task automatic t_variants();
      pins(0, 0, 0, 0, 10'd20, 4'h7);
      step(2);
      chk("R7 float drive in write", drv_f, 0);
      chk("R7 float data in write",  rd_f, 0);
      chk("R8 pass drive in write",  drv_p, 1);
      chk("R8 pass echo",            rd_p, 4'h7);
      pins(0, 0, 0, 1, 10'd20, 4'h2);
      step(2);
      chk("R8 pass drive with out_en_n high", drv_p, 1);
      chk("R8 pass echo with out_en_n high",  rd_p, 4'h2);
      idle();
      pins(0, 0, 1, 1, 10'd20, 4'h0);
      step(2);
      chk("R7 float drive with out_en_n high", drv_f, 0);
      chk("R7 float data with out_en_n high",  rd_f, 0);
      chk("R8 pass read ignores out_en_n",     rd_p, 4'h2);
      idle();
   endtask

   task automatic t_bypass();
      put(10'd30, 4'h1);
      pins(0, 0, 0, 0, 10'd30, 4'h6);
      step(2);
      pins(0, 0, 1, 0, 10'd30, 4'h6);  // close window, keep reading same word
      step(2);
      chk("R9 float first read is new word", rd_f, 4'h6);
      chk("R9 float drive on first read",    drv_f, 1);
      chk("R9 pass first read is new word",  rd_p, 4'h6);
      idle();
   endtask

   initial begin
      t_reset();
      t_basic();
      t_cs_end();
      t_latch();
      t_desel();
      t_variants();
      t_bypass();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule